// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block is one channel of a programmable chip-select unit sitting on a 24-bit address bus. Two configuration words drive it. The base word holds a block base address and a block-size code. The option word qualifies each bus cycle in several ways:

- which byte lanes take part;
- whether reads, writes or both are accepted;
- whether the address strobe or the data strobe times the select;
- how the cycle is acknowledged;
- which address space is accepted;
- for CPU-space cycles, which interrupt-acknowledge level matches and whether an autovector is requested.

On every clock edge the channel compares the current bus cycle with both configuration words. When the address falls inside the decoded block and every qualifier holds, the channel drives its active-low chip select at the next edge. It then returns an active-low data acknowledge after the programmed number of wait states. If the strobe is withdrawn early, the channel drops everything at the following edge. Pin muxing, arbitration between channels and the bus master itself live elsewhere.

Top module: `chipsel_chan`

## Requirements
- R1: Base-word bits 15:3 give address bits 23:11 of the block start. Base-word bits 2:0 give the block size: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M. Address bits below the block size are not compared.
- R2: When the base word and the option word are both zero, the channel never drives `cs_n`, `dsack_n` or `avec_n` low.
- R3: Option bits 14:13 select the byte lanes: bit 14 admits a cycle with `upper_lane`=1, and bit 13 admits one with `lower_lane`=1. The value 00 admits nothing.
- R4: Option bits 12:11 select the direction, with `rw`=1 meaning read: 01 reads only, 10 writes only, 11 both, 00 neither.
- R5: Option bit 10 chooses the timing strobe: 0 follows `as_n` and 1 follows `ds_n`. The other strobe has no effect.
- R6: Option bits 9:6 set the acknowledge. Code 1110 drives `dsack_n` low on the same edge as `cs_n`. Code n (0 to 13) drives it low n+1 edges after `cs_n` goes low.
- R7: Acknowledge code 1111 never drives `dsack_n` low, while `cs_n` still asserts.
- R8: Option bits 5:4 select the address space, with `fc`=111 meaning CPU space and otherwise `fc[2]`=1 meaning supervisor: 00 CPU space, 01 user, 10 supervisor, 11 user or supervisor.
- R9: A CPU-space cycle matches only as an interrupt acknowledge, marked by address bits 19:16 all set. Option bits 3:1 must equal address bits 3:1, or be 000 to match any level. Option bit 0 set drives `avec_n` low together with `cs_n`.
- R10: Once the selected strobe is high at a clock edge, `cs_n`, `dsack_n` and `avec_n` are high after that edge.
- R11: While `rst_n` is low, all three outputs are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_reg | input | 16 | Base word: block start and size code |
| opt_reg | input | 16 | Option word: qualifiers and acknowledge code |
| addr | input | 24 | Bus address |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code / address space |
| upper_lane | input | 1 | Cycle uses the upper data byte |
| lower_lane | input | 1 | Cycle uses the lower data byte |
| cs_n | output | 1 | Chip select, active low |
| dsack_n | output | 1 | Data acknowledge, active low |
| avec_n | output | 1 | Autovector request, active low |

## Verification
Two events can land on the same edge: the wait-state count reaching its target, and the selected strobe being released. The bench provokes this by starting a one-wait-state cycle and then raising `as_n` in the half-cycle just before the edge that would assert `dsack_n`. It passes only if that edge leaves both `cs_n` and `dsack_n` high, so no stray acknowledge is seen. A second collision combines interrupt-acknowledge level matching with the autovector request: `avec_n` must assert on exactly the same edge as `cs_n`, and must not assert for a level mismatch.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;

    localparam int CNT_W     = 4;
    localparam int SIZE_W    = 3;
    localparam logic [3:0] ACK_FAST = 4'hE;
    localparam logic [3:0] ACK_NONE = 4'hF;

    // Registered channel state
    typedef struct packed {
        logic             cs_n;
        logic             dsack_n;
        logic             avec_n;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    // Number of low address bits that sit inside a block of the given size code
    function automatic int unsigned blk_bits(input logic [SIZE_W-1:0] code);
        case (code)
            3'd0:    return 11;
            3'd1:    return 13;
            3'd2:    return 14;
            3'd3:    return 16;
            3'd4:    return 17;
            3'd5:    return 18;
            3'd6:    return 19;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/chipsel_window.sv
module chipsel_window
    import chipsel_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int BASE_LSB = 11
) (
    input  logic [15:0]       base_reg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - BASE_LSB;

    int unsigned      nbits;
    logic [ADDR_W-1:0] bit_ok;

    always_comb nbits = blk_bits(base_reg[SIZE_W-1:0]);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i >= BASE_LSB) begin : g_tag
            assign bit_ok[i] = (i < nbits) ||
                               (addr[i] == base_reg[SIZE_W + i - BASE_LSB]);
        end else begin : g_low
            // below the smallest block: tag is zero and always masked
            assign bit_ok[i] = (i < nbits) || !addr[i];
        end
    end

    assign hit = &bit_ok;

    // keep TAG_W meaningful for the base-word layout
    if (TAG_W + SIZE_W != 16) begin : g_bad_layout
        initial $error("base word layout mismatch");
    end
endmodule

// File: rtl/chipsel_qual.sv
module chipsel_qual #(
    parameter int ADDR_W = 24
) (
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        dir_sel,
    input  logic [1:0]        space_sel,
    input  logic [2:0]        lvl_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [2:0]        fc,
    input  logic              upper_lane,
    input  logic              lower_lane,
    output logic              qual_ok,
    output logic              iack_cyc
);
    logic cpu_space;
    logic lane_ok;
    logic dir_ok;
    logic lvl_ok;
    logic space_ok;

    always_comb begin
        cpu_space = (fc == 3'b111);
        iack_cyc  = cpu_space && (addr[19:16] == 4'hF);
        lane_ok   = (lane_sel[1] && upper_lane) || (lane_sel[0] && lower_lane);
        dir_ok    = rw ? dir_sel[0] : dir_sel[1];
        lvl_ok    = (lvl_sel == 3'd0) || (lvl_sel == addr[3:1]);
        case (space_sel)
            2'b00:   space_ok = iack_cyc && lvl_ok;
            2'b01:   space_ok = !cpu_space && !fc[2];
            2'b10:   space_ok = !cpu_space && fc[2];
            default: space_ok = !cpu_space;
        endcase
        qual_ok = lane_ok && dir_ok && space_ok;
    end
endmodule

// File: rtl/chipsel_ackdec.sv
module chipsel_ackdec
    import chipsel_pkg::*;
(
    input  logic [3:0]       ack_code,
    output logic             ack_en,
    output logic [CNT_W-1:0] ack_target
);
    always_comb begin
        ack_en     = 1'b1;
        ack_target = '0;
        if (ack_code == ACK_NONE) begin
            ack_en = 1'b0;
        end else if (ack_code != ACK_FAST) begin
            ack_target = CNT_W'(ack_code) + 1'b1;
        end
    end
endmodule

// File: rtl/chipsel_chan.sv
module chipsel_chan
    import chipsel_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       base_reg,
    input  logic [15:0]       opt_reg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [2:0]        fc,
    input  logic              upper_lane,
    input  logic              lower_lane,
    output logic              cs_n,
    output logic              dsack_n,
    output logic              avec_n
);
    localparam chan_state_t IDLE = '{cs_n: 1'b1, dsack_n: 1'b1, avec_n: 1'b1, cnt: '0};

    chan_state_t      st_d, st_q;
    logic             hit;
    logic             qual_ok;
    logic             iack_cyc;
    logic             ack_en;
    logic [CNT_W-1:0] ack_target;
    logic             enabled;
    logic             strobe_on;
    logic             sel;

    chipsel_window #(.ADDR_W(ADDR_W)) u_window (
        .base_reg (base_reg),
        .addr     (addr),
        .hit      (hit)
    );

    chipsel_qual #(.ADDR_W(ADDR_W)) u_qual (
        .lane_sel   (opt_reg[14:13]),
        .dir_sel    (opt_reg[12:11]),
        .space_sel  (opt_reg[5:4]),
        .lvl_sel    (opt_reg[3:1]),
        .addr       (addr),
        .rw         (rw),
        .fc         (fc),
        .upper_lane (upper_lane),
        .lower_lane (lower_lane),
        .qual_ok    (qual_ok),
        .iack_cyc   (iack_cyc)
    );

    chipsel_ackdec u_ackdec (
        .ack_code   (opt_reg[9:6]),
        .ack_en     (ack_en),
        .ack_target (ack_target)
    );

    always_comb begin
        enabled   = (base_reg != 16'h0) || (opt_reg[15:0] != 16'h0);
        strobe_on = opt_reg[10] ? !ds_n : !as_n;
        sel       = enabled && hit && qual_ok && strobe_on;

        st_d      = st_q;
        st_d.cs_n = !sel;
        if (!sel) begin
            st_d.cnt = '0;
        end else if (st_q.cs_n) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.dsack_n = !(sel && ack_en && (st_d.cnt >= ack_target));
        st_d.avec_n  = !(sel && iack_cyc && opt_reg[0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign cs_n    = st_q.cs_n;
    assign dsack_n = st_q.dsack_n;
    assign avec_n  = st_q.avec_n;
endmodule

// File: rtl/chipsel_chan_chk.sv
module chipsel_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] base_reg,
    input logic [15:0] opt_reg,
    input logic        as_n,
    input logic        ds_n,
    input logic        rw,
    input logic        upper_lane,
    input logic        lower_lane,
    input logic        cs_n,
    input logic        dsack_n,
    input logic        avec_n
);
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (base_reg == 16'h0 && opt_reg == 16'h0) |=> (cs_n && dsack_n && avec_n));

    assert_no_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!opt_reg[14] || !upper_lane) && (!opt_reg[13] || !lower_lane)) |=> cs_n);

    assert_dir_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rw ? !opt_reg[11] : !opt_reg[12]) |=> cs_n);

    assert_ack_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dsack_n |-> !cs_n);

    assert_no_ack_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_reg[9:6] == 4'hF) |=> dsack_n);

    assert_avec_inside_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !avec_n |-> !cs_n);

    assert_strobe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_reg[10] ? ds_n : as_n) |=> (cs_n && dsack_n && avec_n));
endmodule

bind chipsel_chan chipsel_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_reg   (base_reg),
    .opt_reg    (opt_reg),
    .as_n       (as_n),
    .ds_n       (ds_n),
    .rw         (rw),
    .upper_lane (upper_lane),
    .lower_lane (lower_lane),
    .cs_n       (cs_n),
    .dsack_n    (dsack_n),
    .avec_n     (avec_n)
);

// File: tb/chipsel_chan_bench.sv
`timescale 1ns/1ps
module chipsel_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_reg = '0;
    logic [15:0] opt_reg = '0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b1;
    logic [2:0]  fc = 3'd5;
    logic        upper_lane = 1'b0;
    logic        lower_lane = 1'b0;
    logic        cs_n, dsack_n, avec_n;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chipsel_chan u_chipsel_chan (.*);

    typedef struct packed {
        logic [15:0] base;
        logic [15:0] opt;
        logic [23:0] a;
        logic        rw;
        logic [2:0]  fc;
        logic        up;
        logic        lo;
        logic        sel;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{16'h0500, 16'h6870, 24'h050123, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1}, // R1 inside 2K
        '{16'h0500, 16'h6870, 24'h050800, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R1 past 2K
        '{16'h0005, 16'h5070, 24'h03FFFE, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1}, // R1 R3 R4 upper write
        '{16'h0005, 16'h5070, 24'h03FFFE, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0}, // R3 wrong lane
        '{16'h0005, 16'h5070, 24'h03FFFE, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0}, // R4 read on write-only
        '{16'h0005, 16'h5070, 24'h040000, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0}, // R1 past 256K
        '{16'h0005, 16'h0870, 24'h000010, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R3 lanes 00
        '{16'h0005, 16'h6070, 24'h000010, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R4 dir 00
        '{16'h0005, 16'h7870, 24'h000010, 1'b0, 3'd5, 1'b1, 1'b1, 1'b1}, // R4 dir 11 write
        '{16'hFE02, 16'h6BB0, 24'hFE3FFF, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1}, // R1 16K top
        '{16'hFE02, 16'h6BB0, 24'hFE4000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R1 16K past
        '{16'h0000, 16'h0000, 24'h000000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R2 disabled
        '{16'h0404, 16'h6870, 24'h05FFFF, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1}, // R1 128K top
        '{16'h0404, 16'h6870, 24'h060000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R1 128K past
        '{16'h2007, 16'h6870, 24'h2FFFFF, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1}, // R1 1M top
        '{16'h2007, 16'h6870, 24'h300000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R1 1M past
        '{16'h0500, 16'h6850, 24'h050000, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1}, // R8 user ok
        '{16'h0500, 16'h6850, 24'h050000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0}, // R8 supervisor rejected
        '{16'h0500, 16'h6870, 24'h050000, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0}, // R8 CPU space rejected
        '{16'hFFF8, 16'h2801, 24'hFFF806, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0}, // R8 R9 non-CPU on CPU select
        '{16'hFFF8, 16'h2803, 24'hFFF806, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0}, // R9 level 3 vs 1
        '{16'hFFF8, 16'h2803, 24'hFFF802, 1'b1, 3'd7, 1'b0, 1'b1, 1'b1}  // R9 level 1 match
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] b, input logic [15:0] o, input logic [23:0] a,
                         input logic r, input logic [2:0] f, input logic u, input logic l);
        base_reg = b; opt_reg = o; addr = a; rw = r; fc = f; upper_lane = u; lower_lane = l;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R11: reset holds outputs high even with a matching cycle present
        setup(16'h0500, 16'h6BB0, 24'h050000, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 cs_n in reset", cs_n, 1'b1);
        chk("R11 dsack_n in reset", dsack_n, 1'b1);
        chk("R11 avec_n in reset", avec_n, 1'b1);
        as_n = 1'b1; ds_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R3 R4 R8 R9
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].base, VECS[i].opt, VECS[i].a, VECS[i].rw, VECS[i].fc,
                  VECS[i].up, VECS[i].lo);
            as_n = 1'b0; ds_n = 1'b0;
            @(negedge clk);
            chk($sformatf("R1/R3/R4/R8/R9 table[%0d] cs_n", i), cs_n, !VECS[i].sel);
            idle_bus();
        end

        // R6: code 0001 -> dsack two edges after cs
        setup(16'h0500, 16'h6870, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R6 code1 cs edge1", cs_n, 1'b0);
        chk("R6 code1 dsack edge1", dsack_n, 1'b1);
        @(negedge clk);
        chk("R6 code1 dsack edge2", dsack_n, 1'b1);
        @(negedge clk);
        chk("R6 code1 dsack edge3", dsack_n, 1'b0);
        // R10: release strobe, all high after next edge
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        chk("R10 cs_n after release", cs_n, 1'b1);
        chk("R10 dsack_n after release", dsack_n, 1'b1);
        @(negedge clk);

        // R6: code 0000 -> dsack one edge after cs
        setup(16'h0500, 16'h6830, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R6 code0 dsack edge1", dsack_n, 1'b1);
        @(negedge clk);
        chk("R6 code0 dsack edge2", dsack_n, 1'b0);
        idle_bus();

        // R6: fast termination -> dsack with cs
        setup(16'hFE02, 16'h6BB0, 24'hFE0100, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R6 fast cs", cs_n, 1'b0);
        chk("R6 fast dsack", dsack_n, 1'b0);
        idle_bus();

        // R6: code 0011 -> dsack at edge 5
        setup(16'h0500, 16'h68F0, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 code3 dsack edge4", dsack_n, 1'b1);
        @(negedge clk);
        chk("R6 code3 dsack edge5", dsack_n, 1'b0);
        idle_bus();

        // R7: code 1111 never acknowledges
        setup(16'h0500, 16'h6BF0, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 cs asserted", cs_n, 1'b0);
        chk("R7 no dsack", dsack_n, 1'b1);
        idle_bus();

        // R5: data-strobe timed select ignores as_n
        setup(16'h0500, 16'h6C70, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b1;
        @(negedge clk);
        chk("R5 ds-timed waits for ds_n", cs_n, 1'b1);
        ds_n = 1'b0;
        @(negedge clk);
        chk("R5 ds-timed asserts on ds_n", cs_n, 1'b0);
        idle_bus();
        // R5: address-strobe timed select ignores ds_n
        setup(16'h0500, 16'h6870, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b1;
        @(negedge clk);
        chk("R5 as-timed asserts without ds_n", cs_n, 1'b0);
        idle_bus();

        // R10 + R6 collision: strobe released right before the acknowledge edge
        setup(16'h0500, 16'h6870, 24'h050010, 1'b1, 3'd5, 1'b1, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        chk("R10 collision cs_n", cs_n, 1'b1);
        chk("R10 collision dsack_n", dsack_n, 1'b1);
        @(negedge clk);

        // R9: autovector alongside cs
        setup(16'hFFF8, 16'h2801, 24'hFFF806, 1'b1, 3'd7, 1'b0, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R9 iack cs", cs_n, 1'b0);
        chk("R9 avec asserted", avec_n, 1'b0);
        idle_bus();
        setup(16'hFFF8, 16'h2800, 24'hFFF806, 1'b1, 3'd7, 1'b0, 1'b1);
        as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R9 no avec when bit0 clear", avec_n, 1'b1);
        idle_bus();

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule